// File: doc/BRIEF.md
# Coalescing EOI Tracker

This block watches a single interrupt source, for example a periodic timer tick, and keeps that source from stacking up deliveries that no destination has acknowledged yet. When the source is delivered, the block records which destinations received it in a bitmap, one bit per destination, and counts them. Each destination later returns an end-of-interrupt pulse on its own line. While any acknowledgement is outstanding, a fresh assertion of the source is flagged as coalesced, and the interrupt sequencer drops it instead of servicing it.

Working out which destinations a delivery reaches is done upstream. This block receives only the resulting destination set and a success flag. A restore operation rebuilds the tracking state from two per-destination vectors: whether the destination matches the routing entry, and whether the vector is still pending there. A synchronous clear empties everything. A delivery that arrives while acknowledgements are outstanding breaks the protocol. It is refused and raises an error flag.

Top module: `coal_eoi_tracker`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `pending_cnt` is 0, `dest_bits` is 0 and `err_busy` is 0.
- R2: `coalesced` is 1 exactly when `src_assert` is 1 and `pending_cnt` is nonzero. It is a combinational output with no register delay.
- R3: A delivery (`dlv_fire`=1, `dlv_ok`=1) accepted while `pending_cnt` is 0 loads `dest_bits` with `dlv_dest`, and loads `pending_cnt` with the number of ones in `dlv_dest`. Both take effect on the next clock edge.
- R4: An accepted delivery with `dlv_ok`=0 (the delivery failed) leaves `dest_bits` at 0 and `pending_cnt` at 0.
- R5: On each edge, every `eoi_pulse` bit i whose `dest_bits` bit i is set clears that bit. `pending_cnt` drops by the number of such bits, and several may arrive in the same cycle.
- R6: An `eoi_pulse` bit whose `dest_bits` bit is already clear changes neither `dest_bits` nor `pending_cnt`.
- R7: `clear_req`=1 sets `pending_cnt`, `dest_bits` and `err_busy` to 0 on the next edge.
- R8: `restore_req`=1 replaces the state on the next edge. `dest_bits` becomes `rs_match & rs_pending`, and `pending_cnt` becomes its number of ones, whatever the earlier state was.
- R9: A `dlv_fire` while `pending_cnt` is nonzero is refused. `dest_bits` and `pending_cnt` are left as they were, except for EOIs in the same cycle. `err_busy` becomes 1 and stays 1 until a clear or a reset.
- R10: `pending_cnt` always equals the number of ones in `dest_bits`. It never wraps below zero.
- R11: When requests coincide, clear beats restore, restore beats delivery, and a delivery beats EOIs. A delivery that is overridden never raises `err_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_req | input | 1 | Synchronous clear of all tracking state |
| restore_req | input | 1 | Rebuild the state from `rs_match` and `rs_pending` |
| rs_match | input | N_DEST | Destinations that match the source's routing entry |
| rs_pending | input | N_DEST | Destinations that still hold the vector pending |
| dlv_fire | input | 1 | A delivery of the tracked source takes place |
| dlv_ok | input | 1 | The delivery reached its destinations |
| dlv_dest | input | N_DEST | Destinations the delivery reached |
| eoi_pulse | input | N_DEST | Per-destination end-of-interrupt pulses |
| src_assert | input | 1 | A new assertion of the tracked source |
| coalesced | output | 1 | The assertion must be dropped as coalesced |
| pending_cnt | output | CNT_W | Number of outstanding acknowledgements |
| dest_bits | output | N_DEST | Destinations that still owe an acknowledgement |
| err_busy | output | 1 | A delivery was attempted with acknowledgements outstanding |

## Verification
The bench delivers two dozen arithmetic destination patterns, including the empty set and sets dense in ones. It then retires each pattern one EOI at a time, in ascending order for some patterns and descending order for others. This catches a counter that drifts away from the bitmap, and a design that decrements on an EOI for a bit that is already clear. Both faults show up as a count that is off by one, or that wraps to 31. A burst of several EOIs in one cycle exposes a design that subtracts only one per edge. A failed delivery exposes a design that loads the destination set anyway. A refused delivery while the count is nonzero exposes a design that overwrites the bitmap, or that forgets the sticky error. Coinciding clear, restore and delivery requests expose a wrong priority order. A restore over stale state exposes a restore that merges with the old bitmap instead of replacing it.

// File: rtl/coal_pkg.sv
package coal_pkg;
   typedef enum logic [1:0] {
      OP_TRACK   = 2'd0,   // apply EOI pulses only
      OP_CLEAR   = 2'd1,
      OP_RESTORE = 2'd2,
      OP_LOAD    = 2'd3    // accepted delivery
   } coal_op_e;
endpackage

// File: rtl/coal_popcount.sv
module coal_popcount #(
   parameter int WIDTH = 16,
   parameter int OUT_W = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] vec,
   output logic [OUT_W-1:0] ones
);
   always_comb begin
      ones = '0;
      for (int i = 0; i < WIDTH; i++) begin
         ones = ones + OUT_W'(vec[i]);
      end
   end
endmodule

// File: rtl/coal_arbiter.sv
module coal_arbiter
   import coal_pkg::*;
(
   input  logic     clear_req,
   input  logic     restore_req,
   input  logic     dlv_fire,
   input  logic     busy,
   output coal_op_e op,
   output logic     reject
);
   always_comb begin
      op     = OP_TRACK;
      reject = 1'b0;
      if (clear_req) begin
         op = OP_CLEAR;
      end else if (restore_req) begin
         op = OP_RESTORE;
      end else if (dlv_fire) begin
         if (busy) reject = 1'b1;
         else      op     = OP_LOAD;
      end
   end
endmodule

// File: rtl/coal_next.sv
module coal_next
   import coal_pkg::*;
#(
   parameter int N_DEST = 16,
   parameter int CNT_W  = $clog2(N_DEST + 1)
) (
   input  coal_op_e          op,
   input  logic [N_DEST-1:0] map_q,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic [N_DEST-1:0] dlv_dest,
   input  logic              dlv_ok,
   input  logic [N_DEST-1:0] rs_vec,
   input  logic [N_DEST-1:0] eoi,
   output logic [N_DEST-1:0] map_d,
   output logic [CNT_W-1:0]  cnt_d
);
   logic [N_DEST-1:0] hit, load_vec;
   logic [CNT_W-1:0]  hit_cnt, load_cnt, rs_cnt;

   assign hit      = eoi & map_q;
   assign load_vec = dlv_ok ? dlv_dest : '0;

   coal_popcount #(.WIDTH(N_DEST), .OUT_W(CNT_W)) u_pc_hit  (.vec(hit),      .ones(hit_cnt));
   coal_popcount #(.WIDTH(N_DEST), .OUT_W(CNT_W)) u_pc_load (.vec(load_vec), .ones(load_cnt));
   coal_popcount #(.WIDTH(N_DEST), .OUT_W(CNT_W)) u_pc_rs   (.vec(rs_vec),   .ones(rs_cnt));

   always_comb begin
      unique case (op)
         OP_CLEAR: begin
            map_d = '0;
            cnt_d = '0;
         end
         OP_RESTORE: begin
            map_d = rs_vec;
            cnt_d = rs_cnt;
         end
         OP_LOAD: begin
            map_d = load_vec;
            cnt_d = load_cnt;
         end
         default: begin
            map_d = map_q & ~hit;
            // guard against underflow: saturate at zero
            cnt_d = (hit_cnt > cnt_q) ? '0 : cnt_q - hit_cnt;
         end
      endcase
   end
endmodule

// File: rtl/coal_eoi_tracker.sv
module coal_eoi_tracker
   import coal_pkg::*;
#(
   parameter int N_DEST     = 16,
   parameter bit ERR_STICKY = 1'b1,
   localparam int CNT_W     = $clog2(N_DEST + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_req,
   input  logic              restore_req,
   input  logic [N_DEST-1:0] rs_match,
   input  logic [N_DEST-1:0] rs_pending,
   input  logic              dlv_fire,
   input  logic              dlv_ok,
   input  logic [N_DEST-1:0] dlv_dest,
   input  logic [N_DEST-1:0] eoi_pulse,
   input  logic              src_assert,
   output logic              coalesced,
   output logic [CNT_W-1:0]  pending_cnt,
   output logic [N_DEST-1:0] dest_bits,
   output logic              err_busy
);
   generate
      if (N_DEST < 1 || N_DEST > 64) begin : g_bad_cfg
         $error("coal_eoi_tracker: N_DEST must lie in 1..64");
      end
   endgenerate

   coal_op_e          op;
   logic              reject;
   logic [N_DEST-1:0] map_q, map_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;

   coal_arbiter u_arb (
      .clear_req  (clear_req),
      .restore_req(restore_req),
      .dlv_fire   (dlv_fire),
      .busy       (cnt_q != '0),
      .op         (op),
      .reject     (reject)
   );

   coal_next #(.N_DEST(N_DEST), .CNT_W(CNT_W)) u_next (
      .op      (op),
      .map_q   (map_q),
      .cnt_q   (cnt_q),
      .dlv_dest(dlv_dest),
      .dlv_ok  (dlv_ok),
      .rs_vec  (rs_match & rs_pending),
      .eoi     (eoi_pulse),
      .map_d   (map_d),
      .cnt_d   (cnt_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q <= '0;
         cnt_q <= '0;
      end else begin
         map_q <= map_d;
         cnt_q <= cnt_d;
      end
   end

   generate
      if (ERR_STICKY) begin : g_err_sticky
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         err_busy <= 1'b0;
            else if (clear_req) err_busy <= 1'b0;
            else if (reject)    err_busy <= 1'b1;
         end
      end else begin : g_err_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) err_busy <= 1'b0;
            else        err_busy <= reject;
         end
      end
   endgenerate

   assign coalesced   = src_assert && (cnt_q != '0);
   assign pending_cnt = cnt_q;
   assign dest_bits   = map_q;

   // R10: count and bitmap stay consistent
   a_r10_cnt_tracks_map: assert property (@(posedge clk) disable iff (!rst_n)
      pending_cnt == CNT_W'($countones(dest_bits)));

   // R9: refused delivery leaves state untouched
   a_r9_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_fire && pending_cnt != '0 && !clear_req && !restore_req && eoi_pulse == '0
      |=> $stable(dest_bits) && $stable(pending_cnt) && err_busy);

   // R7: clear empties everything
   a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      clear_req |=> pending_cnt == '0 && dest_bits == '0 && !err_busy);

   // R8: restore rebuilds the bitmap from match and pending
   a_r8_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
      restore_req && !clear_req |=> dest_bits == $past(rs_match & rs_pending));

   // R6: EOIs on clear bits change nothing
   a_r6_stray_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_req && !restore_req && !dlv_fire && (eoi_pulse & dest_bits) == '0
      |=> $stable(dest_bits) && $stable(pending_cnt));

   // R2: a nonempty accepted delivery makes the next assertion coalesce
   a_r2_coalesce_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_fire && dlv_ok && pending_cnt == '0 && !clear_req && !restore_req && dlv_dest != '0
      |=> !src_assert || coalesced);
endmodule

// File: tb/coal_eoi_tracker_test.sv
module coal_eoi_tracker_test;
   localparam int N = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear_req = 1'b0, restore_req = 1'b0;
   logic [N-1:0]  rs_match = '0, rs_pending = '0;
   logic          dlv_fire = 1'b0, dlv_ok = 1'b0;
   logic [N-1:0]  dlv_dest = '0, eoi_pulse = '0;
   logic          src_assert = 1'b0;
   logic          coalesced;
   logic [4:0]    pending_cnt;
   logic [N-1:0]  dest_bits;
   logic          err_busy;

   int checks = 0;
   int errors = 0;
   logic [N-1:0] model;

   always #2 clk = ~clk;   // 250 MHz

   coal_eoi_tracker #(.N_DEST(N)) uut (
      .clk(clk), .rst_n(rst_n), .clear_req(clear_req), .restore_req(restore_req),
      .rs_match(rs_match), .rs_pending(rs_pending), .dlv_fire(dlv_fire),
      .dlv_ok(dlv_ok), .dlv_dest(dlv_dest), .eoi_pulse(eoi_pulse),
      .src_assert(src_assert), .coalesced(coalesced), .pending_cnt(pending_cnt),
      .dest_bits(dest_bits), .err_busy(err_busy)
   );

   task automatic chk(input longint act, input longint exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // compare outputs against the bench model (R10 consistency included)
   task automatic chk_state(input string tag);
      chk(dest_bits, model, {tag, " map"});
      chk(pending_cnt, $countones(model), {tag, " cnt R10"});
   endtask

   task automatic idle_inputs();
      clear_req = 0; restore_req = 0; dlv_fire = 0; dlv_ok = 0;
      dlv_dest = '0; eoi_pulse = '0; rs_match = '0; rs_pending = '0;
   endtask

   task automatic tick();
      @(posedge clk); #1;
      idle_inputs();
   endtask

   task automatic do_clear();
      clear_req = 1; tick(); model = '0;
   endtask

   task automatic do_deliver(input logic [N-1:0] d, input logic ok);
      dlv_fire = 1; dlv_ok = ok; dlv_dest = d; tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      // R1
      chk(pending_cnt, 0, "R1 cnt");
      chk(dest_bits, 0, "R1 map");
      chk(err_busy, 0, "R1 err");
      src_assert = 1; #1;
      chk(coalesced, 0, "R2 idle no coalesce");

      // R3/R5/R6/R2 sweep
      for (int k = 0; k < 24; k++) begin
         logic [N-1:0] pat;
         pat = N'((k * 40503) ^ (k << 3));
         do_clear();
         do_deliver(pat, 1'b1);
         model = pat;
         chk_state("R3 load");
         src_assert = 1; #1;
         chk(coalesced, pat != 0, "R2 coalesce after load");
         for (int i = 0; i < N; i++) begin
            int b;
            b = k[0] ? (N - 1 - i) : i;
            eoi_pulse = N'(1) << b;
            tick();
            model[b] = 1'b0;
            chk_state(pat[b] ? "R5 eoi set bit" : "R6 eoi clear bit");
         end
         // a second stray EOI on an empty map
         eoi_pulse = pat; tick();
         chk_state("R6 stray after drain");
         #1 chk(coalesced, 0, "R2 drained");
      end

      // R4 failed delivery
      do_clear();
      do_deliver(16'hBEEF, 1'b0);
      chk_state("R4 failed delivery");
      chk(err_busy, 0, "R4 no err");

      // R5 several EOIs in one cycle
      do_deliver(16'h0F0F, 1'b1); model = 16'h0F0F;
      eoi_pulse = 16'h00FF; tick(); model = 16'h0F00;
      chk_state("R5 burst eoi");

      // R9 refused delivery
      do_deliver(16'hF0F0, 1'b1);
      chk_state("R9 refused keeps map");
      chk(err_busy, 1, "R9 err set");
      eoi_pulse = 16'h0100; tick(); model = 16'h0E00;
      chk(err_busy, 1, "R9 err sticky");
      chk_state("R9 eoi after refuse");
      do_clear();
      chk(err_busy, 0, "R7 clear drops err");
      chk_state("R7 clear");

      // R8 restore over stale state
      do_deliver(16'hFFFF, 1'b1); model = 16'hFFFF;
      for (int j = 0; j < 6; j++) begin
         logic [N-1:0] m, p;
         m = N'(j * 13107 + 257);
         p = N'(~(j * 4369));
         restore_req = 1; rs_match = m; rs_pending = p; tick();
         model = m & p;
         chk_state("R8 restore");
      end

      // R11 priority
      clear_req = 1; restore_req = 1; rs_match = '1; rs_pending = '1; tick();
      model = '0;
      chk_state("R11 clear over restore");
      restore_req = 1; rs_match = 16'h00F3; rs_pending = 16'h0F31;
      dlv_fire = 1; dlv_ok = 1; dlv_dest = 16'hAAAA; tick();
      model = 16'h0031;
      chk_state("R11 restore over delivery");
      chk(err_busy, 0, "R11 no err on overridden delivery");
      dlv_fire = 1; dlv_ok = 1; dlv_dest = 16'h5555; clear_req = 1; tick();
      model = '0;
      chk_state("R11 clear over delivery");
      chk(err_busy, 0, "R11 clear no err");

      // R1 reset mid-activity
      do_deliver(16'h1234, 1'b1);
      rst_n = 0; #1;
      chk(pending_cnt, 0, "R1 async reset cnt");
      chk(dest_bits, 0, "R1 async reset map");
      @(posedge clk); #1 rst_n = 1;

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule